// File: doc/BRIEF.md
# Rolling Shutter Row Sequencer

This block sets the row timing of a progressive-scan pixel array read out with an electronic rolling shutter. Time is divided into line periods of a fixed number of clocks. In each line period the sequencer may clear one row (start of integration) and may read one row (end of integration). The read row follows the cleared row by a programmable number of line periods, so the exposure is fixed by that count alone. Rows are visited in ascending order from row 0. A frame lasts a programmable number of line periods; the periods past the last active row are vertical blanking.

Two operating modes exist. In continuous mode, frames follow one another without gaps once the block is out of reset and out of standby. In triggered mode, the block waits idle until a rising edge on an asynchronous trigger input, then runs exactly one frame: a lead-in during which the first rows are cleared, then the readout, then idle again. A small parallel write port holds the mode, the frame length and the exposure. A standby input freezes the timing in place, and an active-low asynchronous reset restores every setting.

Top module: `rolling_row_seq`

## Requirements
- R1: While `rst_n` is low, all four strobes are low; after reset the mode is continuous and frame length and exposure hold their parameter defaults.
- R2: Row r of a frame is cleared (`rst_stb`, `rst_row`=r) in line period r of that frame, counted from the first clear of row 0, and read (`rd_stb`, `rd_row`=r) exactly E line periods later, E being the applied exposure; each strobe lasts one clock, at the first clock of a line period of `ROW_CLKS` clocks.
- R3: In continuous mode the clear of row r in frame k falls k·F line periods after that of frame 0, F being the applied frame length.
- R4: A written exposure of 0 is applied as 1 and one of F or more as F−1.
- R5: A written frame length below `ACTIVE_ROWS`+1 is applied as `ACTIVE_ROWS`+1.
- R6: Frame length and exposure are captured when a sequence starts and again at each later frame boundary in continuous mode; a write during a triggered frame leaves that frame unchanged and applies to the next one.
- R7: While `standby` is high, no strobe is issued and the line timing is frozen; on release the timing resumes where it stopped; an idle block does not start in standby.
- R8: In continuous mode the sequence never stops once running.
- R9: In triggered mode, each rising edge of `trig_in` (after two-flop synchronization) seen while idle produces exactly one frame: all active rows cleared once and read once, then idle.
- R10: A trigger edge arriving while a frame is running is ignored.
- R11: `frame_start` pulses together with the read of row 0; `frame_end` pulses for one clock at the first clock after the line period in which the last active row was read.
- R12: Write address 0 bit 0 selects the mode (1 = triggered, 0 = continuous), address 1 the frame length in line periods, address 2 the exposure in line periods; writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Freezes sequencing while high |
| trig_in | input | 1 | Asynchronous trigger for one frame in triggered mode |
| cfg_we | input | 1 | Write strobe for the setting registers |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | LINE_W | Write data |
| rst_stb | output | 1 | One-clock strobe: clear the row on `rst_row` |
| rst_row | output | $clog2(ACTIVE_ROWS) | Row to clear |
| rd_stb | output | 1 | One-clock strobe: read the row on `rd_row` |
| rd_row | output | $clog2(ACTIVE_ROWS) | Row to read |
| frame_start | output | 1 | Pulse with the read of row 0 |
| frame_end | output | 1 | Pulse after the last active row is read |

## Verification
A corrupted line counter or lead-in value shows up at once as a wrong row number on the next strobe, and a wrong exposure register shows as a read strobe landing a whole number of line periods early or late, visible within one exposure window after the first clear. A sequencer that restarts on a stray trigger, or that fails to stop, shows as an extra clear of row 0 within one line period of the fault, while a frozen-timing fault in standby shifts every following strobe by a non-multiple of the line period. The scoreboard therefore timestamps every strobe in line periods relative to the first clear of a run, counting only clocks outside standby, and compares kind, row and time for each.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  // register select codes on the write port
  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_FRAME = 2'd1,
    SEL_EXPO  = 2'd2,
    SEL_SPARE = 2'd3
  } cfg_sel_e;

  // frame length must leave at least one blanking line
  function automatic int unsigned fit_frame(input int unsigned req,
                                            input int unsigned active);
    return (req < active + 1) ? active + 1 : req;
  endfunction

  // exposure kept between one line and one line short of a frame
  function automatic int unsigned fit_expo(input int unsigned req,
                                           input int unsigned frame);
    if (req == 0) return 1;
    if (req > frame - 1) return frame - 1;
    return req;
  endfunction

  // line index at which a fresh sequence starts clearing row 0
  function automatic int unsigned lead_line(input int unsigned frame,
                                            input int unsigned expo);
    return frame - expo;
  endfunction

  // clear pointer runs expo lines ahead of the read pointer, modulo frame
  function automatic int unsigned ahead_row(input int unsigned line,
                                            input int unsigned expo,
                                            input int unsigned frame);
    int unsigned s;
    s = line + expo;
    return (s >= frame) ? s - frame : s;
  endfunction

  function automatic logic ahead_wraps(input int unsigned line,
                                       input int unsigned expo,
                                       input int unsigned frame);
    return (line + expo) >= frame;
  endfunction

endpackage

// File: rtl/rrs_trig_sync.sv
module rrs_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic trig_rise
);
  // STAGES synchronizing flops plus one for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], trig_async};
  end

  assign trig_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/rrs_cfg_bank.sv
module rrs_cfg_bank
  import rrs_pkg::*;
#(
  parameter int ACTIVE_ROWS = 960,
  parameter int LINE_W      = 12,
  parameter int DEF_FRAME   = 990,
  parameter int DEF_EXPO    = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [LINE_W-1:0] wdata,
  output logic              single_mode,
  output logic [LINE_W-1:0] frame_fit,
  output logic [LINE_W-1:0] expo_fit
);
  logic [LINE_W-1:0] frame_raw;
  logic [LINE_W-1:0] expo_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_mode <= 1'b0;
      frame_raw   <= LINE_W'(DEF_FRAME);
      expo_raw    <= LINE_W'(DEF_EXPO);
    end else if (we) begin
      case (cfg_sel_e'(addr))
        SEL_MODE:  single_mode <= wdata[0];
        SEL_FRAME: frame_raw   <= wdata;
        SEL_EXPO:  expo_raw    <= wdata;
        default:   ;
      endcase
    end
  end

  assign frame_fit = LINE_W'(fit_frame(32'(frame_raw), ACTIVE_ROWS));
  assign expo_fit  = LINE_W'(fit_expo(32'(expo_raw), 32'(frame_fit)));
endmodule

// File: rtl/rrs_row_timer.sv
module rrs_row_timer #(
  parameter int ROW_CLKS = 1650
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic hold,
  output logic line_first,
  output logic line_done
);
  localparam int CNT_W = (ROW_CLKS > 1) ? $clog2(ROW_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ROW_CLKS - 1);

  logic [CNT_W-1:0] cnt;
  logic             live;

  assign live = run & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clear)              cnt <= '0;
    else if (live) cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
  end

  assign line_first = live & (cnt == '0);
  assign line_done  = live & (cnt == CNT_LAST);
endmodule

// File: rtl/rolling_row_seq.sv
module rolling_row_seq
  import rrs_pkg::*;
#(
  parameter int ACTIVE_ROWS = 960,
  parameter int ROW_CLKS    = 1650,
  parameter int LINE_W      = 12,
  parameter int DEF_FRAME   = 990,
  parameter int DEF_EXPO    = 500,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_W      = $clog2(ACTIVE_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              trig_in,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [LINE_W-1:0] cfg_wdata,
  output logic              rst_stb,
  output logic [ROW_W-1:0]  rst_row,
  output logic              rd_stb,
  output logic [ROW_W-1:0]  rd_row,
  output logic              frame_start,
  output logic              frame_end
);
  localparam logic [LINE_W-1:0] ACT_L  = LINE_W'(ACTIVE_ROWS);
  localparam logic [LINE_W-1:0] LAST_L = LINE_W'(ACTIVE_ROWS - 1);

  // named internal events, also watched by the checker
  logic              single_mode;
  logic [LINE_W-1:0] frame_fit, expo_fit;
  logic              trig_rise;
  logic              start, line_first, line_done, leave_last, stop_now;
  logic              frame_wrap;
  logic              run_q, pre_q, end_q;
  logic [LINE_W-1:0] line_q, frame_q, expo_q;
  logic [LINE_W-1:0] ahead;
  logic              ahead_wrapped, rst_ok, rd_ok;

  rrs_cfg_bank #(
    .ACTIVE_ROWS(ACTIVE_ROWS), .LINE_W(LINE_W),
    .DEF_FRAME(DEF_FRAME), .DEF_EXPO(DEF_EXPO)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .single_mode(single_mode), .frame_fit(frame_fit), .expo_fit(expo_fit)
  );

  rrs_trig_sync #(.STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_async(trig_in), .trig_rise(trig_rise)
  );

  rrs_row_timer #(.ROW_CLKS(ROW_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(start), .run(run_q), .hold(standby),
    .line_first(line_first), .line_done(line_done)
  );

  // start: idle, awake, and either continuous or a fresh trigger edge
  assign start      = ~run_q & ~standby & (single_mode ? trig_rise : 1'b1);
  assign frame_wrap = line_done & (line_q == frame_q - 1'b1);
  assign leave_last = line_done & ~pre_q & (line_q == LAST_L);
  assign stop_now   = leave_last & single_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pre_q   <= 1'b0;
      end_q   <= 1'b0;
      line_q  <= '0;
      frame_q <= '0;
      expo_q  <= '0;
    end else begin
      end_q <= leave_last;
      if (start) begin
        run_q   <= 1'b1;
        pre_q   <= 1'b1;
        frame_q <= frame_fit;
        expo_q  <= expo_fit;
        line_q  <= LINE_W'(lead_line(32'(frame_fit), 32'(expo_fit)));
      end else if (frame_wrap) begin
        line_q <= '0;
        pre_q  <= 1'b0;
        if (!pre_q) begin
          frame_q <= frame_fit;
          expo_q  <= expo_fit;
        end
      end else if (stop_now) begin
        run_q  <= 1'b0;
        line_q <= '0;
      end else if (line_done) begin
        line_q <= line_q + 1'b1;
      end
    end
  end

  // clear pointer derived from the read pointer and the exposure
  assign ahead         = LINE_W'(ahead_row(32'(line_q), 32'(expo_q), 32'(frame_q)));
  assign ahead_wrapped = ahead_wraps(32'(line_q), 32'(expo_q), 32'(frame_q));
  // in triggered mode, clears belonging to the next frame are suppressed
  assign rst_ok = (ahead < ACT_L) & ~(single_mode & ~pre_q & ahead_wrapped);
  assign rd_ok  = ~pre_q & (line_q < ACT_L);

  assign rst_stb     = line_first & rst_ok;
  assign rst_row     = ahead[ROW_W-1:0];
  assign rd_stb      = line_first & rd_ok;
  assign rd_row      = line_q[ROW_W-1:0];
  assign frame_start = rd_stb & (line_q == '0);
  assign frame_end   = end_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int ACTIVE_ROWS = 960,
  parameter int ROW_CLKS    = 1650,
  parameter int LINE_W      = 12,
  parameter int ROW_W       = $clog2(ACTIVE_ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              single_mode,
  input logic              run_q,
  input logic              pre_q,
  input logic [LINE_W-1:0] frame_q,
  input logic [LINE_W-1:0] expo_q,
  input logic              rst_stb,
  input logic [ROW_W-1:0]  rst_row,
  input logic              rd_stb,
  input logic [ROW_W-1:0]  rd_row,
  input logic              frame_start,
  input logic              frame_end
);
  localparam logic [ROW_W:0]  ACT_R = (ROW_W+1)'(ACTIVE_ROWS);
  localparam logic [LINE_W-1:0] ACT_L = LINE_W'(ACTIVE_ROWS);

  a_r2_rd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> ({1'b0, rd_row} < ACT_R));
  a_r2_rst_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rst_stb |-> ({1'b0, rst_row} < ACT_R));
  a_r2_rows_differ: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_stb && rd_stb) |-> (rst_row != rd_row));
  a_r4_expo_window: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (expo_q != '0) && (expo_q < frame_q));
  a_r5_frame_floor: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (frame_q > ACT_L));
  a_r7_standby_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && $past(standby)) |-> ($stable(rd_row) && $stable(rst_row)));
  a_r8_video_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !single_mode) |=> run_q);
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> !$rose(pre_q));
  a_r11_start_row0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (rd_stb && rd_row == '0));
  a_r11_end_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  generate
    if (ROW_CLKS > 1) begin : g_spacing
      a_r2_rd_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);
    end
  endgenerate
endmodule

bind rolling_row_seq rrs_checker #(
  .ACTIVE_ROWS(ACTIVE_ROWS), .ROW_CLKS(ROW_CLKS), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .single_mode(single_mode),
  .run_q(run_q), .pre_q(pre_q), .frame_q(frame_q), .expo_q(expo_q),
  .rst_stb(rst_stb), .rst_row(rst_row), .rd_stb(rd_stb), .rd_row(rd_row),
  .frame_start(frame_start), .frame_end(frame_end)
);

// File: tb/test_rolling_row_seq.sv
`timescale 1ns/1ps
module test_rolling_row_seq;
  localparam int A  = 8;
  localparam int RC = 4;
  localparam int LW = 8;
  localparam int RW = $clog2(A);
  localparam int K_RST = 0, K_RD = 1, K_FS = 2, K_FE = 3;

  logic clk = 0, rst_n = 0, standby = 1, trig_in = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = '0;
  logic [LW-1:0] cfg_wdata = '0;
  logic rst_stb, rd_stb, frame_start, frame_end;
  logic [RW-1:0] rst_row, rd_row;

  always #2 clk = ~clk;  // 250 MHz

  rolling_row_seq #(.ACTIVE_ROWS(A), .ROW_CLKS(RC), .LINE_W(LW),
                    .DEF_FRAME(11), .DEF_EXPO(4)) i_rolling_row_seq (
    .clk(clk), .rst_n(rst_n), .standby(standby), .trig_in(trig_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rst_stb(rst_stb), .rst_row(rst_row), .rd_stb(rd_stb), .rd_row(rd_row),
    .frame_start(frame_start), .frame_end(frame_end));

  typedef struct { int t; int kind; int row; } ev_t;
  ev_t exp_q[$];
  int checks = 0, fails = 0;
  int acyc = 0, base = 0, t_limit = 0;
  bit armed = 0, base_ok = 0;
  string cur_req = "R1";

  // expected events: row r of frame k cleared at k*F+r, read E later
  task automatic plan_run(input int F, input int E, input bit single, input int limit);
    exp_q.delete();
    t_limit = limit; base_ok = 0; armed = 1;
    for (int t = 0; t < limit; t++) begin
      int k, r, u;
      k = t / F; r = t % F;
      if (r < A && (!single || k == 0)) exp_q.push_back('{t, K_RST, r});
      if (t >= E) begin
        u = t - E; k = u / F; r = u % F;
        if (r < A && (!single || k == 0)) begin
          exp_q.push_back('{t, K_RD, r});
          if (r == 0) exp_q.push_back('{t, K_FS, 0});
        end
      end
      if (t >= E + 1) begin
        u = t - E - 1; k = u / F; r = u % F;
        if (r == A - 1 && (!single || k == 0)) exp_q.push_back('{t, K_FE, 0});
      end
    end
  endtask

  task automatic consume(input int kind, input int row);
    int d, t;
    ev_t e;
    string tag;
    tag = (kind >= K_FS) ? "R11" : "R2";
    if (!base_ok) begin base = acyc; base_ok = 1; end
    d = acyc - base;
    t = d / RC;
    if (t >= t_limit) return;
    checks++;
    if (d % RC != 0) begin
      fails++;
      $display("FAIL %s/%s: event kind %0d off line grid, offset %0d expected 0",
               tag, cur_req, kind, d % RC);
      return;
    end
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL %s/%s: unexpected kind %0d row %0d at line %0d, expected none",
               tag, cur_req, kind, row, t);
      return;
    end
    e = exp_q.pop_front();
    if (e.t != t || e.kind != kind || e.row != row) begin
      fails++;
      $display("FAIL %s/%s: got kind %0d row %0d line %0d, expected kind %0d row %0d line %0d",
               tag, cur_req, kind, row, t, e.kind, e.row, e.t);
    end
  endtask

  // monitor: timestamps in clocks spent outside standby
  always @(negedge clk) begin
    if (rst_n && !standby) acyc++;
    if (rst_n && armed) begin
      if (rst_stb)     consume(K_RST, int'(rst_row));
      if (rd_stb)      consume(K_RD,  int'(rd_row));
      if (frame_start) consume(K_FS,  0);
      if (frame_end)   consume(K_FE,  0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int v);
    cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = LW'(v);
    tick(1);
    cfg_we = 0;
  endtask

  // R1: reset with standby high, strobes quiet during reset
  task automatic restart();
    armed = 0; standby = 1;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    check(!rst_stb && !rd_stb, "R1 strobes in reset", int'(rst_stb | rd_stb), 0);
    check(!frame_start && !frame_end, "R1 frame marks in reset",
          int'(frame_start | frame_end), 0);
    rst_n = 1;
    tick(2);
  endtask

  task automatic drain(input string req, input int maxc);
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < maxc) begin tick(1); n++; end
    tick(2 * RC);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic pulse_trig();
    trig_in = 1; tick(3); trig_in = 0;
  endtask

  initial begin
    tick(1);
    // R1 R2 R8 R11: defaults F=11 E=4 in continuous mode
    restart();
    cur_req = "R1";
    plan_run(11, 4, 0, 30);
    standby = 0;
    drain("R8 default continuous frames", 400);

    // R3 R7: F=12 E=3 with a standby pause in mid-line
    restart();
    wr(1, 12); wr(2, 3);
    cur_req = "R3";
    plan_run(12, 3, 0, 40);
    standby = 0;
    tick(40);
    @(negedge clk); while (!rd_stb) @(negedge clk);
    tick(1);
    cur_req = "R7";
    standby = 1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      check(!rd_stb && !rst_stb, "R7 no strobe in standby", int'(rd_stb | rst_stb), 0);
    end
    tick(1);
    standby = 0;
    drain("R3 R7 frame period after standby", 600);

    // R4 R5 R12: clamped values, spare address ignored
    restart();
    wr(1, 5); wr(2, 20); wr(3, 1);
    cur_req = "R4 R5 R12";
    plan_run(9, 8, 0, 30);
    standby = 0;
    drain("R4 R5 clamped timing", 400);

    // R9 R12: triggered mode stays idle without a trigger
    restart();
    wr(0, 1); wr(1, 10); wr(2, 0);
    cur_req = "R9";
    plan_run(10, 1, 1, 60);
    standby = 0;
    tick(40);
    check(exp_q.size() > 0, "R9 idle before trigger", 0, 1);
    check(!base_ok, "R9 no strobe before trigger", int'(base_ok), 0);
    pulse_trig();
    @(negedge clk); while (!rd_stb) @(negedge clk);
    // R10: trigger during frame ignored; R6: exposure write deferred
    cur_req = "R10 R6";
    tick(1);
    pulse_trig();
    wr(2, 5);
    drain("R9 R10 one frame per trigger", 400);
    tick(80);
    check(exp_q.size() == 0, "R10 no second frame", exp_q.size(), 0);

    // R6: next trigger uses the new exposure
    cur_req = "R6";
    plan_run(10, 5, 1, 60);
    pulse_trig();
    drain("R6 new exposure on next frame", 400);
    tick(40);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    n = 0;
    while (n < 150000) begin @(posedge clk); n++; end
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", n);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule